// File: doc/BRIEF.md
# Multi-Cycle Datapath with Shared Memory

This block is the datapath half of a small processor core that runs each instruction over several short clock cycles rather than one long one. A single word-addressed memory holds both the program and its data, and one ALU does all the arithmetic: advancing the program counter, building branch targets, forming load/store addresses and executing register-to-register operations. Results move between steps through named latches: an instruction register, two operand latches (A and B), an ALU result latch and a memory data latch.

The datapath makes no sequencing decisions of its own. An external controller drives every multiplexer select and write enable on each cycle. It reads back the opcode and function fields from the instruction register and the ALU zero flag. A typical instruction runs as fetch, decode, execute, then optional memory-access and write-back steps. A branch finishes after three cycles, an ALU operation or a store after four, and a load after five. A fill port lets boot logic place program and data words into the memory, normally while reset is held.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the PC, the instruction register, A, B, the ALU result latch and the memory data latch all clear to zero, and every register-file entry clears to zero; the memory keeps its contents.
- R2: Fetch step (`addr_sel`=0, `ir_wr`=1, `alu_a_sel`=0, `alu_b_sel`=1 selecting constant 4, `alu_op`=0 add, `pc_src`=0 selecting the live ALU result, `pc_wr`=1): the memory word at PC[7:2] is loaded into the instruction register, and the PC becomes PC+4 at the same edge.
- R3: On every edge, A and B load the register-file entries named by instruction bits [25:21] and [20:16], whether or not they are needed. With `alu_b_sel`=3 (sign-extended bits [15:0] shifted left by 2) and `alu_a_sel`=0, the ALU result latch receives PC + 4·offset, which is the speculative branch target.
- R4: `alu_op` encodes 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than (1 or 0). With `alu_a_sel`=1 and `alu_b_sel`=0 the ALU result latch receives A op B at the next edge. `zero_o` is high exactly when the current ALU result is zero.
- R5: With `alu_a_sel`=1 and `alu_b_sel`=2 (sign-extended bits [15:0]), the ALU result latch receives base + offset, and negative offsets are handled correctly.
- R6: With `pc_wr_if_eq`=1, `pc_wr`=0 and `pc_src`=1, the PC loads the ALU result latch when `zero_o` is high and holds its value otherwise.
- R7: With `addr_sel`=1 and `mem_wr`=1, B is written to the memory word addressed by the ALU result latch.
- R8: On every edge, the memory data latch captures the word at the selected address. With `rf_wr`=1, `dst_sel`=0 and `wb_sel`=1, that latch is written to the register named by bits [20:16].
- R9: With `rf_wr`=1, `dst_sel`=1 and `wb_sel`=0, the ALU result latch is written to the register named by bits [15:11]. Register 0 always reads as zero, even after a write to it.
- R10: `pc_src`=2 with `pc_wr`=1 loads the PC with {PC[31:28], instruction bits [25:0], 2'b00}.
- R11: With `ir_wr`=0, the instruction register (and so `op_o` = bits [31:26] and `fn_o` = bits [5:0]) holds its value. With both PC enables low, the PC holds its value.
- R12: `fill_we` writes `fill_data` to word `fill_addr`, including while reset is held, and has priority over `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_we | input | 1 | Boot fill write enable |
| fill_addr | input | MEM_AW | Boot fill word index |
| fill_data | input | XLEN | Boot fill word |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_if_eq | input | 1 | PC write gated by the zero flag |
| addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result latch |
| mem_wr | input | 1 | Memory write of B |
| ir_wr | input | 1 | Instruction register load |
| rf_wr | input | 1 | Register file write |
| dst_sel | input | 1 | Destination: 0 bits [20:16], 1 bits [15:11] |
| wb_sel | input | 1 | Write-back source: 0 ALU latch, 1 memory data latch |
| alu_a_sel | input | 1 | ALU first operand: 0 PC, 1 A |
| alu_b_sel | input | 2 | ALU second operand: 0 B, 1 four, 2 offset, 3 offset·4 |
| alu_op | input | 3 | ALU function code |
| pc_src | input | 2 | PC source: 0 live ALU, 1 ALU latch, 2 jump target |
| op_o | output | 6 | Instruction bits [31:26] |
| fn_o | output | 6 | Instruction bits [5:0] |
| zero_o | output | 1 | Live ALU result equals zero |
| pc_o | output | XLEN | Program counter |
| a_o | output | XLEN | Operand latch A |
| b_o | output | XLEN | Operand latch B |
| aluout_o | output | XLEN | ALU result latch |
| mdr_o | output | XLEN | Memory data latch |

## Verification
The hardest situation to reach is a taken conditional branch. It needs the ALU result latch to still hold the target that was computed speculatively during decode, while the execute step compares two registers that a preceding store-then-load sequence has made equal. The stimulus runs a short program from the filled memory: loads, every ALU function, a store, a reload of the stored word, a branch that is not taken, then a taken branch whose operands come from that store/reload pair. A negative-offset load and a jump follow. The reference model mirrors every latch on every cycle, so a stale branch target or a mis-gated PC write shows up on the cycle it happens.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int INSN_W = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  localparam logic [1:0] BSEL_REG  = 2'd0;
  localparam logic [1:0] BSEL_FOUR = 2'd1;
  localparam logic [1:0] BSEL_IMM  = 2'd2;
  localparam logic [1:0] BSEL_IMM4 = 2'd3;

  localparam logic [1:0] PCSRC_ALU  = 2'd0;
  localparam logic [1:0] PCSRC_LAT  = 2'd1;
  localparam logic [1:0] PCSRC_JUMP = 2'd2;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_op_e         func,
  output logic [XLEN-1:0] res,
  output logic            is_zero
);
  always_comb begin
    unique case (func)
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIDX_W-1:0] rd_idx1,
  input  logic [RIDX_W-1:0] rd_idx2,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_val,
  output logic [XLEN-1:0]   rd_val1,
  output logic [XLEN-1:0]   rd_val2
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en && wr_idx != '0) begin
      regs[wr_idx] <= wr_val;
    end
  end

  assign rd_val1 = (rd_idx1 == '0) ? '0 : regs[rd_idx1];
  assign rd_val2 = (rd_idx2 == '0) ? '0 : regs[rd_idx2];
endmodule

// File: rtl/mc_memory.sv
module mc_memory #(
  parameter int XLEN  = 32,
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MEM_WORDS = 64,
  parameter int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_we,
  input  logic [MEM_AW-1:0] fill_addr,
  input  logic [XLEN-1:0]   fill_data,
  input  logic              pc_wr,
  input  logic              pc_wr_if_eq,
  input  logic              addr_sel,
  input  logic              mem_wr,
  input  logic              ir_wr,
  input  logic              rf_wr,
  input  logic              dst_sel,
  input  logic              wb_sel,
  input  logic              alu_a_sel,
  input  logic [1:0]        alu_b_sel,
  input  logic [2:0]        alu_op,
  input  logic [1:0]        pc_src,
  output logic [5:0]        op_o,
  output logic [5:0]        fn_o,
  output logic              zero_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   a_o,
  output logic [XLEN-1:0]   b_o,
  output logic [XLEN-1:0]   aluout_o,
  output logic [XLEN-1:0]   mdr_o
);
  localparam int IMM_W = 16;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, mdr_q;

  logic [RIDX_W-1:0] src1_idx, src2_idx, dst_idx;
  logic [XLEN-1:0]   rf_rd1, rf_rd2, rf_wd;
  logic [XLEN-1:0]   imm_sx, imm_x4;
  logic [XLEN-1:0]   alu_a, alu_b, alu_y;
  logic              alu_zero;
  logic [MEM_AW-1:0] mem_idx, wr_idx;
  logic [XLEN-1:0]   mem_rdata, wr_word;
  logic              wr_en;
  logic [XLEN-1:0]   pc_next;
  logic              pc_en;

  // Instruction field decode
  assign src1_idx = ir_q[21 +: RIDX_W];
  assign src2_idx = ir_q[16 +: RIDX_W];
  assign dst_idx  = dst_sel ? ir_q[11 +: RIDX_W] : ir_q[16 +: RIDX_W];
  assign imm_sx   = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_x4   = {imm_sx[XLEN-3:0], 2'b00};

  assign rf_wd = wb_sel ? mdr_q : aluout_q;

  mc_regfile #(.XLEN(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_idx1 (src1_idx),
    .rd_idx2 (src2_idx),
    .wr_en   (rf_wr),
    .wr_idx  (dst_idx),
    .wr_val  (rf_wd),
    .rd_val1 (rf_rd1),
    .rd_val2 (rf_rd2)
  );

  // Shared ALU operand selection
  assign alu_a = alu_a_sel ? a_q : pc_q;

  always_comb begin
    unique case (alu_b_sel)
      BSEL_REG:  alu_b = b_q;
      BSEL_FOUR: alu_b = XLEN'(4);
      BSEL_IMM:  alu_b = imm_sx;
      default:   alu_b = imm_x4;
    endcase
  end

  mc_alu #(.XLEN(XLEN)) u_alu (
    .opa     (alu_a),
    .opb     (alu_b),
    .func    (alu_op_e'(alu_op)),
    .res     (alu_y),
    .is_zero (alu_zero)
  );

  // Shared memory: fetch from PC, data from the ALU latch
  assign mem_idx = addr_sel ? aluout_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];
  assign wr_en   = fill_we | mem_wr;
  assign wr_idx  = fill_we ? fill_addr : mem_idx;
  assign wr_word = fill_we ? fill_data : b_q;

  mc_memory #(.XLEN(XLEN), .WORDS(MEM_WORDS), .AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_word),
    .raddr (mem_idx),
    .rdata (mem_rdata)
  );

  // PC update
  always_comb begin
    unique case (pc_src)
      PCSRC_ALU:  pc_next = alu_y;
      PCSRC_LAT:  pc_next = aluout_q;
      PCSRC_JUMP: pc_next = {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};
      default:    pc_next = pc_q;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_if_eq & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (pc_en) pc_q <= pc_next;
      if (ir_wr) ir_q <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_y;
      mdr_q    <= mem_rdata;
    end
  end

  assign op_o     = ir_q[31:26];
  assign fn_o     = ir_q[5:0];
  assign zero_o   = alu_zero;
  assign pc_o     = pc_q;
  assign a_o      = a_q;
  assign b_o      = b_q;
  assign aluout_o = aluout_q;
  assign mdr_o    = mdr_q;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            pc_wr,
  input logic            pc_wr_if_eq,
  input logic            ir_wr,
  input logic            alu_a_sel,
  input logic [1:0]      alu_b_sel,
  input logic [2:0]      alu_op,
  input logic [1:0]      pc_src,
  input logic            zero_o,
  input logic [5:0]      op_o,
  input logic [5:0]      fn_o,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] aluout_o
);
  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1)
      AST_RESET_CLEAR: assert (pc_o == '0 && aluout_o == '0 && op_o == '0); // R1
  end

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_if_eq) |=> $stable(pc_o)); // R11

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable({op_o, fn_o})); // R11

  AST_PC_INC: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src == 2'd0 && !alu_a_sel && alu_b_sel == 2'd1 && alu_op == 3'd0)
    |=> pc_o == $past(pc_o) + XLEN'(4)); // R2

  AST_BRANCH_SKIP: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && pc_wr_if_eq && !zero_o) |=> $stable(pc_o)); // R6

  AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && pc_wr_if_eq && zero_o && pc_src == 2'd1) |=> pc_o == $past(aluout_o)); // R6
endmodule

bind mc_datapath mc_datapath_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc_wr       (pc_wr),
  .pc_wr_if_eq (pc_wr_if_eq),
  .ir_wr       (ir_wr),
  .alu_a_sel   (alu_a_sel),
  .alu_b_sel   (alu_b_sel),
  .alu_op      (alu_op),
  .pc_src      (pc_src),
  .zero_o      (zero_o),
  .op_o        (op_o),
  .fn_o        (fn_o),
  .pc_o        (pc_o),
  .aluout_o    (aluout_o)
);

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;
  localparam int XLEN = 32;
  localparam int MW   = 64;
  localparam int MAW  = 6;

  logic clk = 1'b0;
  logic rst;
  logic fill_we;
  logic [MAW-1:0] fill_addr;
  logic [XLEN-1:0] fill_data;
  logic pc_wr, pc_wr_if_eq, addr_sel, mem_wr, ir_wr, rf_wr, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, pc_src;
  logic [2:0] alu_op;
  logic [5:0] op_o, fn_o;
  logic zero_o;
  logic [XLEN-1:0] pc_o, a_o, b_o, aluout_o, mdr_o;

  always #10 clk = ~clk;

  mc_datapath #(.XLEN(XLEN), .MEM_WORDS(MW)) u_mc_datapath (
    .clk(clk), .rst(rst), .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .pc_wr(pc_wr), .pc_wr_if_eq(pc_wr_if_eq), .addr_sel(addr_sel), .mem_wr(mem_wr),
    .ir_wr(ir_wr), .rf_wr(rf_wr), .dst_sel(dst_sel), .wb_sel(wb_sel),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .op_o(op_o), .fn_o(fn_o), .zero_o(zero_o), .pc_o(pc_o), .a_o(a_o), .b_o(b_o),
    .aluout_o(aluout_o), .mdr_o(mdr_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] m_pc, m_ir, m_a, m_b, m_alu, m_mdr;
  logic [31:0] rf_m [32];
  logic [31:0] mem_m [MW];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] alu_f(logic [2:0] f, logic [31:0] x, logic [31:0] y);
    case (f)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic step(string tag, bit pcw, bit pcc, bit adr, bit mw, bit irw, bit rfw,
                      bit dsel, bit wsel, bit asel, logic [1:0] bsel, logic [2:0] aop,
                      logic [1:0] psrc);
    logic [31:0] ai, bi, y, addr, rdw, sx, npc;
    logic [31:0] n_a, n_b;
    bit z;
    int dst;
    pc_wr = pcw; pc_wr_if_eq = pcc; addr_sel = adr; mem_wr = mw; ir_wr = irw;
    rf_wr = rfw; dst_sel = dsel; wb_sel = wsel; alu_a_sel = asel; alu_b_sel = bsel;
    alu_op = aop; pc_src = psrc;
    #1;
    sx = {{16{m_ir[15]}}, m_ir[15:0]};
    ai = asel ? m_a : m_pc;
    case (bsel)
      2'd0: bi = m_b;
      2'd1: bi = 32'd4;
      2'd2: bi = sx;
      default: bi = sx << 2;
    endcase
    y = alu_f(aop, ai, bi);
    z = (y == 32'd0);
    chk(tag, "zero flag", {31'd0, zero_o}, {31'd0, z});
    addr = adr ? m_alu : m_pc;
    rdw = mem_m[addr[7:2]];
    n_a = rf_m[m_ir[25:21]];
    n_b = rf_m[m_ir[20:16]];
    if (psrc == 2'd0) npc = y;
    else if (psrc == 2'd1) npc = m_alu;
    else npc = {m_pc[31:28], m_ir[25:0], 2'b00};
    @(posedge clk);
    @(negedge clk);
    if (mw) mem_m[addr[7:2]] = m_b;
    if (rfw) begin
      dst = dsel ? int'(m_ir[15:11]) : int'(m_ir[20:16]);
      if (dst != 0) rf_m[dst] = wsel ? m_mdr : m_alu;
    end
    if (pcw || (pcc && z)) m_pc = npc;
    if (irw) m_ir = rdw;
    m_a = n_a; m_b = n_b; m_alu = y; m_mdr = rdw;
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "opcode", {26'd0, op_o}, {26'd0, m_ir[31:26]});
    chk(tag, "funct", {26'd0, fn_o}, {26'd0, m_ir[5:0]});
    chk(tag, "latch A", a_o, m_a);
    chk(tag, "latch B", b_o, m_b);
    chk(tag, "alu latch", aluout_o, m_alu);
    chk(tag, "mem data latch", mdr_o, m_mdr);
  endtask

  task automatic run_one();
    logic [5:0] op;
    logic [2:0] f;
    bit first;
    first = (m_pc == 32'd0);
    step("R2", 1, 0, 0, 0, 1, 0, 0, 0, 0, 2'd1, 3'd0, 2'd0);   // fetch
    step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 3'd0, 2'd0);   // decode
    op = m_ir[31:26];
    case (op)
      6'd0: begin
        case (m_ir[5:0])
          6'd32: f = 3'd0;
          6'd34: f = 3'd1;
          6'd36: f = 3'd2;
          6'd37: f = 3'd3;
          default: f = 3'd4;
        endcase
        step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, f, 2'd0);
        step("R9", 0, 0, 0, 0, 0, 1, 1, 0, 0, 2'd0, 3'd0, 2'd0);
      end
      6'd35: begin
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 3'd0, 2'd0);
        step(first ? "R12" : "R8", 0, 0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
        step("R8", 0, 0, 0, 0, 0, 1, 0, 1, 0, 2'd0, 3'd0, 2'd0);
      end
      6'd43: begin
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 3'd0, 2'd0);
        step("R7", 0, 0, 1, 1, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
      end
      6'd4:  step("R6", 0, 1, 0, 0, 0, 0, 0, 0, 1, 2'd0, 3'd1, 2'd1);
      default: step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd2);
    endcase
  endtask

  initial begin
    logic [31:0] prog [20];
    rst = 1'b1; fill_we = 1'b0; fill_addr = '0; fill_data = '0;
    pc_wr = 0; pc_wr_if_eq = 0; addr_sel = 0; mem_wr = 0; ir_wr = 0; rf_wr = 0;
    dst_sel = 0; wb_sel = 0; alu_a_sel = 0; alu_b_sel = 0; alu_op = 0; pc_src = 0;
    prog[0]  = enc_i(35, 0, 1, 128);
    prog[1]  = enc_i(35, 0, 2, 132);
    prog[2]  = enc_r(1, 2, 3, 32);
    prog[3]  = enc_r(2, 1, 4, 34);
    prog[4]  = enc_r(1, 2, 5, 36);
    prog[5]  = enc_r(1, 2, 6, 37);
    prog[6]  = enc_r(2, 1, 7, 42);
    prog[7]  = enc_r(1, 2, 8, 42);
    prog[8]  = enc_i(43, 0, 3, 136);
    prog[9]  = enc_i(35, 0, 9, 136);
    prog[10] = enc_i(4, 1, 2, 5);
    prog[11] = enc_i(4, 3, 9, 2);
    prog[12] = enc_r(1, 1, 12, 32);
    prog[13] = enc_r(1, 1, 13, 32);
    prog[14] = enc_r(1, 1, 0, 32);
    prog[15] = enc_i(35, 9, 10, -4);
    prog[16] = {6'd2, 26'd18};
    prog[17] = enc_r(1, 1, 14, 32);
    prog[18] = enc_r(10, 0, 11, 37);
    prog[19] = 32'd0;
    // Fill memory while reset is held
    for (int i = 0; i < MW; i++) begin
      @(negedge clk);
      if (i < 20) mem_m[i] = prog[i];
      else if (i == 32) mem_m[i] = 32'd7;
      else if (i == 33) mem_m[i] = 32'hFFFF_FFFD;
      else mem_m[i] = 32'(i) * 32'h0101_0101;
      fill_we = 1'b1; fill_addr = MAW'(i); fill_data = mem_m[i];
    end
    @(negedge clk);
    fill_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_ir = 0; m_a = 0; m_b = 0; m_alu = 0; m_mdr = 0;
    for (int i = 0; i < 32; i++) rf_m[i] = 0;
    chk("R1", "pc after reset", pc_o, 32'd0);
    chk("R1", "alu latch after reset", aluout_o, 32'd0);
    chk("R1", "mem data latch after reset", mdr_o, 32'd0);
    chk("R1", "A after reset", a_o, 32'd0);
    chk("R1", "opcode after reset", {26'd0, op_o}, 32'd0);
    for (int k = 0; k < 16; k++) run_one();
    chk("R10", "jump landed", m_pc, 32'd76);
    chk("R6", "branch skipped filler", rf_m[12], 32'd0);
    chk("R9", "register 0 stays zero", rf_m[0], 32'd0);
    chk("R7", "stored sum in memory model", mem_m[34], 32'd4);
    // Idle cycle: no IR load, no PC write
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 3'd0, 2'd0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 3'd3, 2'd0);
    chk("R8", "A shows reloaded word", a_o, prog[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule